// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits on the controller side of a raw NAND flash interface. It turns single requests into pin-level waveforms on the flash bus. A request is one of four kinds: send a command byte, send a run of address bytes, write a run of data words, or read a run of data words. For each request the block lowers the chip enable, sets the command-latch and address-latch levels the operation needs, and produces one write-strobe or read-strobe pulse per item. Each strobe stays low and then high for a programmable number of system clocks. When it finishes, it raises chip enable again, which puts the device in standby.

Outgoing values are placed on the IO bus before the write strobe rises and stay there until the strobe period ends. Read data is captured at the moment the read strobe rises, and the IO drivers are off for the whole read. The write-protect pin is driven from a registered control input. A command marked as modifying, or a data-write request, is refused with an error response while protection is active. A refused request produces no bus activity. A ready/done handshake lets only one request run at a time.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset, and whenever no request is running, chip enable and both strobes are high, both latch enables are low, IO drive is off and `req_ready` is 1.
- R2: A command request (`req_kind`=0) gives exactly one write-strobe pulse with chip enable low, command latch high, address latch low and read strobe high. At the strobe's rising edge, `io_out[7:0]` holds `req_byte` and the upper byte is zero.
- R3: An address request (`req_kind`=1) of length N gives N write-strobe pulses with address latch high and command latch low. Pulse k carries `wr_data[7:0]` of the k-th consumed word, with the upper byte zero, even in wide mode.
- R4: A data-write request (`req_kind`=2) gives N write-strobe pulses with both latch enables low. In wide mode (`cfg_wide`=1) each pulse carries the full 16-bit word. In narrow mode the upper byte is zero.
- R5: A read request (`req_kind`=3) gives N read-strobe pulses with the write strobe high, both latch enables low and IO drive off. Each pulse yields one `rd_valid` beat whose `rd_data` is `io_in` as it was just before the read strobe rose. In narrow mode the upper byte of `rd_data` is zero.
- R6: The write strobe stays low for max(`cfg_we_lo`,1) clocks, and stays high for max(`cfg_we_hi`,1) clocks between pulses of one request. The read strobe follows the same rule with `cfg_re_lo` and `cfg_re_hi`.
- R7: While `nand_wp_n` is 0, a command request with `req_modify`=1, or any data-write request, ends with `req_done` and `req_err` both high. It produces no strobe pulse and no chip-enable low cycle. Command requests with `req_modify`=0 and address requests still run.
- R8: Once a request is accepted, `req_ready` stays low until `req_done`. `req_done` is a single-cycle pulse. A `req_valid` raised while busy is ignored and causes no bus activity.
- R9: `nand_wp_n` follows `wp_allow` one clock later and is 0 after reset.
- R10: An address, write or read request with length 0 behaves as a request of length 1.
- R11: The value on `io_out` does not change from the write strobe's falling edge through its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_len | input | 12 | Item count for address, write and read requests |
| req_byte | input | 8 | Command byte |
| req_modify | input | 1 | Command alters the array (subject to protection) |
| req_ready | output | 1 | Idle and able to accept |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | With req_done: request refused |
| wr_data | input | 16 | Next address byte or write word |
| wr_take | output | 1 | wr_data is consumed at this clock edge |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | rd_data valid for one cycle |
| cfg_wide | input | 1 | 1 for a 16-bit data bus, 0 for 8-bit |
| cfg_we_lo | input | 8 | Write strobe low clocks |
| cfg_we_hi | input | 8 | Write strobe high clocks |
| cfg_re_lo | input | 8 | Read strobe low clocks |
| cfg_re_hi | input | 8 | Read strobe high clocks |
| wp_allow | input | 1 | 1 lifts write protection |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| io_out | output | 16 | IO bus drive value |
| io_oe | output | 1 | IO bus drive enable |
| io_in | input | 16 | IO bus sampled value |

## Verification
The assertions take for granted that the timing inputs and `cfg_wide` are stable while a request runs. They also take for granted that `wr_data` already holds the next item whenever `wr_take` is high. The bench changes the timing and width settings only between requests, after `req_done` and before the next `req_valid`. It presents the head of its word queue on `wr_data` at every falling clock edge, and it moves `io_in` only while the read strobe is high or right after it falls. Because of this, the capture instant is the only one that can change the read result.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LO    = 3'd2,
        ST_HI    = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic oe;
    } pin_set_t;

    // The request kinds that feed words from wr_data onto the bus.
    function automatic logic uses_wdata(op_kind_t k);
        return (k == OP_ADDR) || (k == OP_WRITE);
    endfunction

    // Kinds refused while the flash is protected.
    function automatic logic needs_unlock(op_kind_t k, logic modify);
        return (k == OP_WRITE) || ((k == OP_CMD) && modify);
    endfunction

    // Pin levels for each sequencer state and request kind.
    function automatic pin_set_t pins_for(seq_state_t st, op_kind_t k);
        pin_set_t p;
        logic busy;
        busy   = (st == ST_SETUP) || (st == ST_LO) || (st == ST_HI);
        p.ce_n = !busy;
        p.cle  = busy && (k == OP_CMD);
        p.ale  = busy && (k == OP_ADDR);
        p.we_n = !((st == ST_LO) && (k != OP_READ));
        p.re_n = !((st == ST_LO) && (k == OP_READ));
        p.oe   = busy && (k != OP_READ);
        return p;
    endfunction

endpackage

// File: rtl/nbs_phase_timer.sv
module nbs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] ticks,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // A requested length of zero is served as one clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (ticks == '0) ? '0 : ticks - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbs_seq_fsm.sv
module nbs_seq_fsm
    import nbs_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  op_kind_t         req_kind,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_modify,
    input  logic             wp_n_q,
    input  logic             tmr_expired,
    output seq_state_t       state,
    output op_kind_t         kind_q,
    output logic             tmr_load,
    output logic             tmr_sel_hi,
    output logic             take,
    output logic             capture,
    output logic             start_cmd,
    output logic             ready,
    output logic             done,
    output logic             err
);
    seq_state_t       state_d;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] left_d;
    logic             err_q;
    logic             err_d;
    op_kind_t         kind_d;
    logic             accept;
    logic             blocked;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign blocked = !wp_n_q && needs_unlock(req_kind, req_modify);

    always_comb begin
        state_d    = state;
        left_d     = left_q;
        err_d      = err_q;
        kind_d     = kind_q;
        tmr_load   = 1'b0;
        tmr_sel_hi = 1'b0;
        take       = 1'b0;
        capture    = 1'b0;
        start_cmd  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                err_d = 1'b0;
                if (accept) begin
                    kind_d = req_kind;
                    if (blocked) begin
                        err_d   = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        start_cmd = (req_kind == OP_CMD);
                        left_d    = (req_kind == OP_CMD || req_len == '0)
                                    ? LEN_W'(1) : req_len;
                        state_d   = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                take     = uses_wdata(kind_q);
                state_d  = ST_LO;
            end
            ST_LO: begin
                if (tmr_expired) begin
                    tmr_load   = 1'b1;
                    tmr_sel_hi = 1'b1;
                    capture    = (kind_q == OP_READ);
                    state_d    = ST_HI;
                end
            end
            ST_HI: begin
                if (tmr_expired) begin
                    if (left_q > LEN_W'(1)) begin
                        left_d   = left_q - 1'b1;
                        tmr_load = 1'b1;
                        take     = uses_wdata(kind_q);
                        state_d  = ST_LO;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= OP_CMD;
            left_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state  <= state_d;
            kind_q <= kind_d;
            left_q <= left_d;
            err_q  <= err_d;
        end
    end

    assign ready = (state == ST_IDLE);
    assign done  = (state == ST_DONE);
    assign err   = (state == ST_DONE) && err_q;
endmodule

// File: rtl/nbs_io_path.sv
module nbs_io_path
    import nbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              start_cmd,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              take,
    input  op_kind_t          kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              capture,
    input  logic [DATA_W-1:0] io_in,
    output logic [DATA_W-1:0] io_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(8'hFF);

    logic [DATA_W-1:0] next_word;
    logic [DATA_W-1:0] in_word;

    // Commands and addresses always travel on the low byte only.
    always_comb begin
        if (kind == OP_WRITE && cfg_wide) begin
            next_word = wr_data;
        end else begin
            next_word = wr_data & LOW_MASK;
        end
        in_word = cfg_wide ? io_in : (io_in & LOW_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_word  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (start_cmd) begin
                io_word <= DATA_W'(cmd_byte);
            end else if (take) begin
                io_word <= next_word;
            end
            if (capture) begin
                rd_data <= in_word;
            end
            rd_valid <= capture;
        end
    end
endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer
    import nbs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_byte,
    input  logic              req_modify,
    output logic              req_ready,
    output logic              req_done,
    output logic              req_err,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              cfg_wide,
    input  logic [CNT_W-1:0]  cfg_we_lo,
    input  logic [CNT_W-1:0]  cfg_we_hi,
    input  logic [CNT_W-1:0]  cfg_re_lo,
    input  logic [CNT_W-1:0]  cfg_re_hi,
    input  logic              wp_allow,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [DATA_W-1:0] io_out,
    output logic              io_oe,
    input  logic [DATA_W-1:0] io_in
);
    seq_state_t       state;
    op_kind_t         kind_q;
    logic             tmr_load;
    logic             tmr_sel_hi;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_ticks;
    logic             capture;
    logic             start_cmd;
    logic             wp_n_q;
    logic [DATA_W-1:0] io_word;
    pin_set_t         pins;

    // Protection level is registered so it holds from reset onward.
    always_ff @(posedge clk) begin
        if (rst) begin
            wp_n_q <= 1'b0;
        end else begin
            wp_n_q <= wp_allow;
        end
    end

    nbs_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (op_kind_t'(req_kind)),
        .req_len    (req_len),
        .req_modify (req_modify),
        .wp_n_q     (wp_n_q),
        .tmr_expired(tmr_expired),
        .state      (state),
        .kind_q     (kind_q),
        .tmr_load   (tmr_load),
        .tmr_sel_hi (tmr_sel_hi),
        .take       (wr_take),
        .capture    (capture),
        .start_cmd  (start_cmd),
        .ready      (req_ready),
        .done       (req_done),
        .err        (req_err)
    );

    always_comb begin
        if (kind_q == OP_READ) begin
            tmr_ticks = tmr_sel_hi ? cfg_re_hi : cfg_re_lo;
        end else begin
            tmr_ticks = tmr_sel_hi ? cfg_we_hi : cfg_we_lo;
        end
    end

    nbs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .ticks  (tmr_ticks),
        .expired(tmr_expired)
    );

    nbs_io_path #(.DATA_W(DATA_W)) u_io (
        .clk      (clk),
        .rst      (rst),
        .cfg_wide (cfg_wide),
        .start_cmd(start_cmd),
        .cmd_byte (req_byte),
        .take     (wr_take),
        .kind     (kind_q),
        .wr_data  (wr_data),
        .capture  (capture),
        .io_in    (io_in),
        .io_word  (io_word),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign pins      = pins_for(state, kind_q);
    assign nand_ce_n = pins.ce_n;
    assign nand_cle  = pins.cle;
    assign nand_ale  = pins.ale;
    assign nand_we_n = pins.we_n;
    assign nand_re_n = pins.re_n;
    assign io_oe     = pins.oe;
    assign io_out    = pins.oe ? io_word : '0;
    assign nand_wp_n = wp_n_q;
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              io_oe,
    input logic [DATA_W-1:0] io_out,
    input logic              req_ready,
    input logic              req_done,
    input logic              req_err
);
    a_r1_strobe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (nand_ce_n && !io_oe && !nand_cle && !nand_ale));

    a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    a_r5_read_undriven: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> (!io_oe && nand_we_n && !nand_cle && !nand_ale));

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !nand_ce_n |-> !req_ready);

    a_r11_io_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(nand_we_n) |-> $stable(io_out));
endmodule

bind nand_bus_sequencer nbs_checker #(.DATA_W(DATA_W)) u_nbs_checker (
    .clk      (clk),
    .rst      (rst),
    .nand_ce_n(nand_ce_n),
    .nand_cle (nand_cle),
    .nand_ale (nand_ale),
    .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n),
    .io_oe    (io_oe),
    .io_out   (io_out),
    .req_ready(req_ready),
    .req_done (req_done),
    .req_err  (req_err)
);

// File: tb/nand_bus_sequencer_bench.sv
module nand_bus_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [11:0] req_len = '0;
    logic [7:0]  req_byte = '0;
    logic        req_modify = 1'b0;
    logic        req_ready, req_done, req_err;
    logic [15:0] wr_data = '0;
    logic        wr_take;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        cfg_wide = 1'b1;
    logic [7:0]  cfg_we_lo = 8'd1, cfg_we_hi = 8'd1, cfg_re_lo = 8'd1, cfg_re_hi = 8'd1;
    logic        wp_allow = 1'b0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic [15:0] io_out;
    logic        io_oe;
    logic [15:0] io_in = 16'hFFFF;

    always #10 clk = ~clk;

    nand_bus_sequencer u_nand_bus_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_len(req_len), .req_byte(req_byte), .req_modify(req_modify),
        .req_ready(req_ready), .req_done(req_done), .req_err(req_err),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .cfg_wide(cfg_wide), .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi),
        .cfg_re_lo(cfg_re_lo), .cfg_re_hi(cfg_re_hi), .wp_allow(wp_allow),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int exp_we_lo = 1, exp_we_hi = 1, exp_re_lo = 1, exp_re_hi = 1;

    logic [17:0] ev_q[$];     // {cle, ale, io}
    logic [15:0] src_q[$];    // words for wr_data
    logic [15:0] rd_q[$];     // expected read beats
    logic [15:0] rd_pat = 16'hC3A0;
    int  we_rises = 0;
    int  re_rises = 0;
    int  ce_low_cycles = 0;
    int  cycles = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (ev_q.size() != 0) check(0, "R8 leftover write events", ev_q.size(), 0);
        if (rd_q.size() != 0) check(0, "R5 leftover read beats", rd_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // wr_data feeder: head of the source queue, popped after each consumption
    bit take_pend = 0;
    always @(negedge clk) begin
        if (take_pend && src_q.size() != 0) void'(src_q.pop_front());
        wr_data   = (src_q.size() != 0) ? src_q[0] : 16'h0000;
        take_pend = wr_take;
    end

    // Monitor / scoreboard
    logic prev_we = 1'b1, prev_re = 1'b1;
    int   we_lo_run = 0, we_hi_run = 0, re_lo_run = 0, re_hi_run = 0;
    bit   we_hi_ok = 0, re_hi_ok = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!nand_ce_n) ce_low_cycles++;
            // write strobe
            if (!nand_we_n) begin
                if (prev_we) begin
                    if (we_hi_ok) check(we_hi_run == exp_we_hi, "R6 WE high width", we_hi_run, exp_we_hi);
                    we_lo_run = 1;
                end else we_lo_run++;
            end else begin
                if (!prev_we) begin
                    logic [17:0] e;
                    we_rises++;
                    check(we_lo_run == exp_we_lo, "R6 WE low width", we_lo_run, exp_we_lo);
                    check(!nand_ce_n && nand_re_n && io_oe, "R2 ce/re/oe at WE rise",
                          {nand_ce_n, nand_re_n, io_oe}, 3'b011);
                    if (ev_q.size() == 0) begin
                        check(0, "R8 unexpected WE pulse", {nand_cle, nand_ale, io_out}, 0);
                    end else begin
                        e = ev_q.pop_front();
                        check({nand_cle, nand_ale, io_out} == e, "R2/R3/R4 latch+IO at WE rise",
                              {nand_cle, nand_ale, io_out}, e);
                    end
                    we_hi_run = 1;
                    we_hi_ok  = 1;
                end else we_hi_run++;
            end
            // read strobe
            if (!nand_re_n) begin
                if (prev_re) begin
                    if (re_hi_ok) check(re_hi_run == exp_re_hi, "R6 RE high width", re_hi_run, exp_re_hi);
                    re_lo_run = 1;
                    io_in = rd_pat;
                    rd_q.push_back(cfg_wide ? rd_pat : {8'h00, rd_pat[7:0]});
                    rd_pat = rd_pat + 16'h0111;
                end else re_lo_run++;
            end else begin
                if (!prev_re) begin
                    re_rises++;
                    check(re_lo_run == exp_re_lo, "R6 RE low width", re_lo_run, exp_re_lo);
                    check(!io_oe && nand_we_n && !nand_cle && !nand_ale && !nand_ce_n,
                          "R5 pin levels in read", {io_oe, nand_we_n, nand_cle, nand_ale}, 4'b0100);
                    io_in = 16'hFFFF;
                    re_hi_run = 1;
                    re_hi_ok  = 1;
                end else re_hi_run++;
            end
            if (nand_ce_n) begin
                we_hi_ok = 0;
                re_hi_ok = 0;
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) check(0, "R5 unexpected rd_valid", rd_data, 0);
                else begin
                    logic [15:0] r;
                    r = rd_q.pop_front();
                    check(rd_data == r, "R5 read data", rd_data, r);
                end
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    // Driver: issues one request and waits for completion.
    task automatic run_op(input logic [1:0] kind, input logic [11:0] len,
                          input logic [7:0] byt, input bit modify, input bit exp_err,
                          input bit poke, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = kind;
        req_len    = len;
        req_byte   = byt;
        req_modify = modify;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {"R8 ready low after accept ", tag}, req_ready, 0);
        if (poke && !req_done) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1;      // ignored: busy
            req_kind  = 2'd0;
            req_byte  = 8'h5A;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!req_done) @(negedge clk);
        check(req_err == exp_err, {"R7 error flag ", tag}, req_err, exp_err);
        @(negedge clk);
        check(!req_done && req_ready, {"R8 single done, back to ready ", tag},
              {req_done, req_ready}, 2'b01);
    endtask

    task automatic set_timing(input int wl, input int wh, input int rl, input int rh);
        cfg_we_lo = 8'(wl); cfg_we_hi = 8'(wh); cfg_re_lo = 8'(rl); cfg_re_hi = 8'(rh);
        exp_we_lo = (wl == 0) ? 1 : wl; exp_we_hi = (wh == 0) ? 1 : wh;
        exp_re_lo = (rl == 0) ? 1 : rl; exp_re_hi = (rh == 0) ? 1 : rh;
    endtask

    task automatic queue_words(input logic [1:0] kind, input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = base + 16'(i * 16'h1357);
            src_q.push_back(w);
            if (kind == 2'd1)      ev_q.push_back({2'b01, 8'h00, w[7:0]});
            else if (cfg_wide)     ev_q.push_back({2'b00, w});
            else                   ev_q.push_back({2'b00, 8'h00, w[7:0]});
        end
    endtask

    initial begin
        int we0, ce0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !io_oe && req_ready,
              "R1 idle pins after reset",
              {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, io_oe, req_ready}, 7'b1110001);
        check(nand_wp_n == 1'b0, "R9 protected after reset", nand_wp_n, 0);

        // R9 protect register follows control one clock later
        wp_allow = 1'b1;
        @(negedge clk);
        check(nand_wp_n == 1'b1, "R9 wp follows control", nand_wp_n, 1);

        // R2 command, modify allowed when unprotected
        set_timing(3, 2, 1, 1);
        ev_q.push_back({2'b10, 16'h0080});
        run_op(2'd0, 12'd0, 8'h80, 1'b1, 1'b0, 1'b0, "R2 cmd");

        // R3 five address bytes, upper bits of wr_data must be dropped
        queue_words(2'd1, 5, 16'hAB12);
        run_op(2'd1, 12'd5, 8'h00, 1'b0, 1'b0, 1'b0, "R3 addr");

        // R4 wide data write
        set_timing(1, 1, 1, 1);
        queue_words(2'd2, 4, 16'h9E31);
        run_op(2'd2, 12'd4, 8'h00, 1'b0, 1'b0, 1'b0, "R4 wide write");

        // R4 narrow data write
        cfg_wide = 1'b0;
        set_timing(2, 4, 1, 1);
        queue_words(2'd2, 3, 16'h7F44);
        run_op(2'd2, 12'd3, 8'h00, 1'b0, 1'b0, 1'b0, "R4 narrow write");

        // R5 narrow read
        set_timing(1, 1, 2, 3);
        run_op(2'd3, 12'd2, 8'h00, 1'b0, 1'b0, 1'b0, "R5 narrow read");

        // R5 wide read, minimum timing
        cfg_wide = 1'b1;
        set_timing(1, 1, 1, 1);
        run_op(2'd3, 12'd4, 8'h00, 1'b0, 1'b0, 1'b0, "R5 wide read");
        check(re_rises == 6, "R5 total read pulses", re_rises, 6);

        // R6 zero timing settings act as one clock
        set_timing(0, 0, 0, 0);
        queue_words(2'd2, 3, 16'h0F0F);
        run_op(2'd2, 12'd3, 8'h00, 1'b0, 1'b0, 1'b0, "R6 zero timing write");
        run_op(2'd3, 12'd2, 8'h00, 1'b0, 1'b0, 1'b0, "R6 zero timing read");

        // R10 length zero behaves as one
        set_timing(2, 2, 2, 2);
        we0 = we_rises;
        queue_words(2'd1, 1, 16'h3344);
        run_op(2'd1, 12'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R10 addr len0");
        check(we_rises - we0 == 1, "R10 one pulse for length 0", we_rises - we0, 1);

        // R7 protection refuses modify command and data write
        wp_allow = 1'b0;
        @(negedge clk);
        we0 = we_rises;
        ce0 = ce_low_cycles;
        run_op(2'd0, 12'd0, 8'h10, 1'b1, 1'b1, 1'b0, "R7 blocked cmd");
        src_q.push_back(16'h1111);
        run_op(2'd2, 12'd2, 8'h00, 1'b0, 1'b1, 1'b0, "R7 blocked write");
        void'(src_q.pop_front());
        check(we_rises == we0, "R7 no WE pulse when refused", we_rises - we0, 0);
        check(ce_low_cycles == ce0, "R7 CE stays high when refused", ce_low_cycles - ce0, 0);
        // R7 plain command and address still run while protected
        ev_q.push_back({2'b10, 16'h0070});
        run_op(2'd0, 12'd0, 8'h70, 1'b0, 1'b0, 1'b0, "R7 plain cmd protected");
        queue_words(2'd1, 2, 16'h2468);
        run_op(2'd1, 12'd2, 8'h00, 1'b0, 1'b0, 1'b0, "R7 addr protected");

        // R8 request raised while busy is ignored
        set_timing(1, 1, 4, 4);
        we0 = we_rises;
        run_op(2'd3, 12'd2, 8'h00, 1'b0, 1'b0, 1'b1, "R8 busy poke");
        repeat (10) @(negedge clk);
        check(we_rises == we0, "R8 poke caused no command", we_rises - we0, 0);
        check(nand_ce_n && req_ready, "R1 idle after all requests",
              {nand_ce_n, req_ready}, 2'b11);

        finish_run();
    end
endmodule